// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block fills the working registers of one DMA channel from descriptors held in memory. A trigger supplies a control word. The flow-mode field of that word says where the descriptor sits and which register it begins with. The size field says how many 16-bit halfwords it holds. The block checks the control word first. It then reads the halfwords one at a time through a valid/ready read port and writes each into the next register in a fixed slot sequence. Finally it sets up the current address, the current descriptor pointer and the current counts that the transfer engine uses.

A channel start loads the register values from the input bus and then runs a load. When the transfer engine reports that a work unit has ended, the block reloads from the registers it already holds. In the list modes this follows the chain, because the fetched next pointer and control word are used for the following load. A successful load ends with a one-cycle `done` strobe and raises `active`. A bad configuration gives `cfg_err`, and a misaligned start address gives `align_err`. Either error leaves the channel inactive.

Control word layout: bits [14:12] flow mode (0 stop, 1 autobuffer, 2 array, 3 small list, 4 large list, 5 to 7 undefined), bits [11:8] descriptor size in halfwords, bits [3:2] element size (0 byte, 1 halfword, 2 word, 3 undefined). The remaining bits are stored but not interpreted.

Top module: `dma_desc_loader`

## Requirements
- R1: A trigger whose control word has flow mode 5, 6 or 7, element size code 3, or a descriptor size outside the range its mode allows, pulses `cfg_err` for one cycle starting one clock after the trigger. No read is issued, `done` stays low and `active` is low afterwards.
- R2: Stop mode (0) and autobuffer mode (1) accept only size 0. They fetch nothing, and `done` rises two clocks after the trigger.
- R3: Array mode (2) accepts sizes 1 to 7. It reads from the current descriptor pointer, and its first halfword goes to the start-address low slot.
- R4: Small-list mode (3) accepts sizes 1 to 8 and reads from the next descriptor pointer. Its first halfword replaces only bits [15:0] of the next pointer; bits [31:16] are kept. Its second halfword goes to the start-address low slot.
- R5: Large-list mode (4) accepts sizes 1 to 9 and reads from the next descriptor pointer. Its first two halfwords replace bits [15:0] and then bits [31:16] of the next pointer.
- R6: The register slots are filled in this order: next pointer low, next pointer high, start address low, start address high, control word, X count, X modify, Y count, Y modify. A descriptor shorter than the remaining slots leaves the later registers unchanged.
- R7: The read port requests one halfword per accepted beat at addresses that rise by 2. While `rd_gnt` is low, the request and its address are held.
- R8: The cycle after the last accepted beat, `done` pulses for one cycle and `active` rises. At that point the current pointer equals the next pointer, the current address equals the start address, and each current count equals its count, with 0 replaced by 0xFFFF.
- R9: The element size in the loaded control word (code 0, 1 or 2 for 1, 2 or 4 bytes) is checked against the start address after the fetch. A start address that is not a multiple of the element size pulses `align_err` instead of `done` and leaves `active` low.
- R10: `unit_done` while active in autobuffer or a list mode starts a reload from the held registers. In stop mode it only clears `active`. `start` and `unit_done` are ignored while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load registers from the input bus and begin a load |
| unit_done | input | 1 | Work unit finished; reload or stop |
| cfg_in | input | 16 | Control word at start |
| next_ptr_in | input | 32 | Next descriptor pointer at start |
| cur_ptr_in | input | 32 | Current descriptor pointer at start |
| saddr_in | input | 32 | Start address at start |
| xcnt_in | input | 16 | X count at start |
| xmod_in | input | 16 | X modify at start |
| ycnt_in | input | 16 | Y count at start |
| ymod_in | input | 16 | Y modify at start |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 32 | Halfword read address |
| rd_gnt | input | 1 | Read accepted; data valid this cycle |
| rd_data | input | 16 | Read data |
| next_ptr | output | 32 | Next descriptor pointer |
| saddr | output | 32 | Start address |
| cfg | output | 16 | Control word |
| xcnt | output | 16 | X count |
| xmod | output | 16 | X modify |
| ycnt | output | 16 | Y count |
| ymod | output | 16 | Y modify |
| cur_ptr | output | 32 | Current descriptor pointer |
| cur_addr | output | 32 | Current address |
| cur_xcnt | output | 16 | Current X count |
| cur_ycnt | output | 16 | Current Y count |
| busy | output | 1 | Load in progress |
| active | output | 1 | Channel loaded and running |
| done | output | 1 | Load completed strobe |
| cfg_err | output | 1 | Configuration error strobe |
| align_err | output | 1 | Start address alignment error strobe |

## Verification
The assertions check the read-port discipline on every cycle. A stalled request holds its address, and each accepted beat advances the address by 2. They also check that the three result strobes never coincide and that `done` lasts one cycle. On every completion they check that the current counts are non-zero and the current address is aligned. Which slot each halfword lands in, which pointer each mode reads from, and the reload after `unit_done` can only be shown by the bench's scenarios: it preloads known descriptors in memory and compares the resulting registers and the logged beat addresses.

// File: rtl/dma_desc_loader.sv
module dma_desc_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        unit_done,
  input  logic [15:0] cfg_in,
  input  logic [31:0] next_ptr_in,
  input  logic [31:0] cur_ptr_in,
  input  logic [31:0] saddr_in,
  input  logic [15:0] xcnt_in,
  input  logic [15:0] xmod_in,
  input  logic [15:0] ycnt_in,
  input  logic [15:0] ymod_in,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_gnt,
  input  logic [15:0] rd_data,
  output logic [31:0] next_ptr,
  output logic [31:0] saddr,
  output logic [15:0] cfg,
  output logic [15:0] xcnt,
  output logic [15:0] xmod,
  output logic [15:0] ycnt,
  output logic [15:0] ymod,
  output logic [31:0] cur_ptr,
  output logic [31:0] cur_addr,
  output logic [15:0] cur_xcnt,
  output logic [15:0] cur_ycnt,
  output logic        busy,
  output logic        active,
  output logic        done,
  output logic        cfg_err,
  output logic        align_err
);
  localparam logic [2:0] FL_STOP = 3'd0, FL_AUTO = 3'd1, FL_ARRAY = 3'd2,
                         FL_SMALL = 3'd3, FL_LARGE = 3'd4;
  localparam logic [3:0] SLOT_SA_LO = 4'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_FINISH} state_t;
  state_t st;

  logic [31:0] fa;
  logic [3:0]  left, slot;
  logic        small_q;

  wire idle       = (st == S_IDLE);
  wire trig_start = start && idle;
  wire held_stop  = (cfg[14:12] == FL_STOP);
  wire trig_unit  = unit_done && idle && active && !held_stop && !start;
  wire stop_unit  = unit_done && idle && active && held_stop && !start;
  wire trig       = trig_start || trig_unit;

  wire [15:0] tc   = trig_start ? cfg_in : cfg;
  wire [2:0]  flow = tc[14:12];
  wire [3:0]  nsz  = tc[11:8];
  wire        unused_cfg_bits = ^{tc[15], tc[7:4], tc[1:0]};

  logic size_ok;
  always_comb begin
    case (flow)
      FL_STOP, FL_AUTO: size_ok = (nsz == 4'd0);
      FL_ARRAY:         size_ok = (nsz >= 4'd1) && (nsz <= 4'd7);
      FL_SMALL:         size_ok = (nsz >= 4'd1) && (nsz <= 4'd8);
      FL_LARGE:         size_ok = (nsz >= 4'd1) && (nsz <= 4'd9);
      default:          size_ok = 1'b0;
    endcase
  end
  wire cfg_ok = size_ok && (tc[3:2] != 2'd3);

  wire [31:0] np_src = trig_start ? next_ptr_in : next_ptr;
  wire [31:0] cp_src = trig_start ? cur_ptr_in : cur_ptr;
  wire [31:0] base   = (flow == FL_ARRAY) ? cp_src : np_src;

  wire misalign = ((cfg[3:2] == 2'd1) && saddr[0]) ||
                  ((cfg[3:2] == 2'd2) && (saddr[1:0] != 2'd0));

  assign rd_req  = (st == S_FETCH);
  assign rd_addr = fa;
  assign busy    = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fa <= '0; left <= '0; slot <= '0; small_q <= 1'b0;
      next_ptr <= '0; saddr <= '0; cfg <= '0;
      xcnt <= '0; xmod <= '0; ycnt <= '0; ymod <= '0;
      cur_ptr <= '0; cur_addr <= '0; cur_xcnt <= '0; cur_ycnt <= '0;
      active <= 1'b0; done <= 1'b0; cfg_err <= 1'b0; align_err <= 1'b0;
    end else begin
      done <= 1'b0; cfg_err <= 1'b0; align_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (trig_start) begin
            cfg <= cfg_in; next_ptr <= next_ptr_in; cur_ptr <= cur_ptr_in;
            saddr <= saddr_in; xcnt <= xcnt_in; xmod <= xmod_in;
            ycnt <= ycnt_in; ymod <= ymod_in;
          end
          if (trig) begin
            active <= 1'b0;
            if (!cfg_ok) cfg_err <= 1'b1;
            else if (nsz == 4'd0) st <= S_FINISH;
            else begin
              st      <= S_FETCH;
              fa      <= base;
              left    <= nsz;
              slot    <= (flow == FL_ARRAY) ? SLOT_SA_LO : 4'd0;
              small_q <= (flow == FL_SMALL);
            end
          end else if (stop_unit) begin
            active <= 1'b0;
          end
        end
        S_FETCH: if (rd_gnt) begin
          case (slot)
            4'd0: next_ptr[15:0]  <= rd_data;
            4'd1: next_ptr[31:16] <= rd_data;
            4'd2: saddr[15:0]     <= rd_data;
            4'd3: saddr[31:16]    <= rd_data;
            4'd4: cfg             <= rd_data;
            4'd5: xcnt            <= rd_data;
            4'd6: xmod            <= rd_data;
            4'd7: ycnt            <= rd_data;
            default: ymod         <= rd_data;
          endcase
          fa   <= fa + 32'd2;
          left <= left - 4'd1;
          slot <= (small_q && slot == 4'd0) ? SLOT_SA_LO : slot + 4'd1;
          if (left == 4'd1) st <= S_FINISH;
        end
        default: begin
          st <= S_IDLE;
          if (cfg[3:2] == 2'd3) cfg_err <= 1'b1;
          else if (misalign) align_err <= 1'b1;
          else begin
            done     <= 1'b1;
            active   <= 1'b1;
            cur_ptr  <= next_ptr;
            cur_addr <= saddr;
            cur_xcnt <= (xcnt == 16'd0) ? 16'hFFFF : xcnt;
            cur_ycnt <= (ycnt == 16'd0) ? 16'hFFFF : ycnt;
          end
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_gnt |=> !rd_req || (rd_addr == $past(rd_addr) + 32'd2)); // R7
  AST_CFG_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !rd_req && !active); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, cfg_err, align_err})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_COUNTS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_xcnt != 16'd0) && (cur_ycnt != 16'd0) && active); // R8
  AST_DONE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !((cfg[3:2] == 2'd1) && cur_addr[0]) &&
             !((cfg[3:2] == 2'd2) && (cur_addr[1:0] != 2'd0))); // R9
endmodule

// File: tb/tb_dma_desc_loader.sv
module tb_dma_desc_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, unit_done = 1'b0;
  logic [15:0] cfg_in = '0, xcnt_in = '0, xmod_in = '0, ycnt_in = '0, ymod_in = '0;
  logic [31:0] next_ptr_in = '0, cur_ptr_in = '0, saddr_in = '0;
  logic rd_req, rd_gnt;
  logic [31:0] rd_addr;
  logic [15:0] rd_data;
  logic [31:0] next_ptr, saddr, cur_ptr, cur_addr;
  logic [15:0] cfg, xcnt, xmod, ycnt, ymod, cur_xcnt, cur_ycnt;
  logic busy, active, done, cfg_err, align_err;

  dma_desc_loader dut (.*);

  always #4 clk = ~clk;

  logic [15:0] mem [256];
  assign rd_data = mem[rd_addr[8:1]];
  logic stall = 1'b0, tog = 1'b0;
  always @(posedge clk) tog <= ~tog;
  assign rd_gnt = !stall || tog;

  int nbeats = 0;
  logic [31:0] baddr [64];
  always @(posedge clk) if (rd_req && rd_gnt) begin
    baddr[nbeats[5:0]] <= rd_addr;
    nbeats <= nbeats + 1;
  end

  int n_tests = 0, n_fail = 0, b0 = 0;
  logic got_d, got_c, got_a;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int fl, input int n, input int ws);
    return {1'b0, fl[2:0], n[3:0], 4'b0, ws[1:0], 2'b0};
  endfunction

  task automatic pulse_start();
    @(negedge clk); b0 = nbeats; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_unit();
    @(negedge clk); b0 = nbeats; unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
  endtask

  task automatic wait_end();
    got_d = 0; got_c = 0; got_a = 0;
    for (int i = 0; i < 200; i++) begin
      if (done || cfg_err || align_err) begin
        got_d = done; got_c = cfg_err; got_a = align_err;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 reset active", active, 0);
    chk("R7 reset rd_req", rd_req, 0);
    chk("R8 reset busy/done", {busy, done, cfg_err, align_err}, 0);
    chk("R8 reset cur_addr", cur_addr, 0);
  endtask

  task automatic t_stop();
    cfg_in = mk(0, 0, 1); saddr_in = 32'h1000; xcnt_in = 0; ycnt_in = 9;
    next_ptr_in = 32'h4444_0000; cur_ptr_in = 32'h0;
    pulse_start();
    chk("R2 stop done not yet", done, 0);
    @(negedge clk);
    chk("R2 stop done at 2 clocks", done, 1);
    chk("R8 cur_xcnt zero->FFFF", cur_xcnt, 16'hFFFF);
    chk("R8 cur_ycnt", cur_ycnt, 9);
    chk("R8 cur_addr", cur_addr, 32'h1000);
    chk("R8 cur_ptr from next", cur_ptr, 32'h4444_0000);
    chk("R2 stop no reads", nbeats - b0, 0);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R8 active", active, 1);
    pulse_unit(); wait_end();
    chk("R10 stop unit clears active", active, 0);
    chk("R10 stop unit no reload", {got_d, got_c, got_a}, 0);
  endtask

  task automatic t_auto();
    cfg_in = mk(1, 0, 2); saddr_in = 32'h2000; xcnt_in = 3; ycnt_in = 0;
    pulse_start(); wait_end();
    chk("R2 auto done", got_d, 1);
    chk("R8 auto cur_ycnt", cur_ycnt, 16'hFFFF);
    pulse_unit(); wait_end();
    chk("R10 auto reload done", got_d, 1);
    chk("R2 auto no reads", nbeats - b0, 0);
    chk("R10 auto active", active, 1);
  endtask

  task automatic bad(input string rq, input logic [15:0] c);
    cfg_in = c; saddr_in = 0;
    pulse_start(); wait_end();
    chk(rq, {got_c, got_d, active}, 3'b100);
    chk("R1 no reads on error", nbeats - b0, 0);
  endtask

  task automatic t_bad();
    bad("R1 flow 5", mk(5, 1, 0));
    bad("R1 array size 0", mk(2, 0, 0));
    bad("R1 small size 9", mk(3, 9, 0));
    bad("R1 large size 10", mk(4, 10, 0));
    bad("R1 stop size 2", mk(0, 2, 0));
    bad("R1 elem code 3", mk(0, 0, 3));
  endtask

  task automatic t_array(input logic busy_poke);
    mem[8'h10] = 16'h1234; mem[8'h11] = 16'hABCD; mem[8'h12] = mk(2, 7, 1);
    mem[8'h13] = 16'h0010; mem[8'h14] = 16'h0002; mem[8'h15] = 16'h0003;
    mem[8'h16] = 16'hFFF0;
    cfg_in = mk(2, 7, 1); cur_ptr_in = 32'h20; next_ptr_in = 32'h5555_0000;
    saddr_in = 0; stall = busy_poke;
    pulse_start();
    if (busy_poke) begin
      @(negedge clk); start = 1'b1; cfg_in = mk(5, 0, 0); saddr_in = 32'hFFFF_FFFF;
      @(negedge clk); start = 1'b0;
      @(negedge clk); unit_done = 1'b1;
      @(negedge clk); unit_done = 1'b0;
    end
    wait_end(); stall = 0;
    chk("R3 array done", {got_d, got_c}, 2'b10);
    chk("R3 array first addr", baddr[b0[5:0]], 32'h20);
    chk("R7 array last addr", baddr[(b0 + 6) & 63], 32'h2C);
    chk("R7 array beats", nbeats - b0, 7);
    chk("R6 saddr", saddr, 32'hABCD_1234);
    chk("R6 cfg", cfg, mk(2, 7, 1));
    chk("R6 xmod", xmod, 2);
    chk("R6 ymod", ymod, 16'hFFF0);
    chk("R8 cur_addr", cur_addr, 32'hABCD_1234);
    chk("R8 cur_ptr", cur_ptr, 32'h5555_0000);
    chk("R8 counts", {cur_xcnt, cur_ycnt}, {16'h10, 16'h3});
    if (busy_poke) chk("R10 start ignored while busy", next_ptr, 32'h5555_0000);
  endtask

  task automatic t_small();
    mem[8'h20] = 16'h0060; mem[8'h21] = 16'h0100; mem[8'h22] = 16'h0002;
    mem[8'h23] = mk(3, 8, 2); mem[8'h24] = 0; mem[8'h25] = 4;
    mem[8'h26] = 5; mem[8'h27] = 8;
    cfg_in = mk(3, 8, 2); next_ptr_in = 32'h0007_0040; stall = 1;
    pulse_start(); wait_end(); stall = 0;
    chk("R4 small done", got_d, 1);
    chk("R4 small first addr", baddr[b0[5:0]], 32'h0007_0040);
    chk("R4 small low half only", next_ptr, 32'h0007_0060);
    chk("R4 small saddr", saddr, 32'h0002_0100);
    chk("R4 small ymod", ymod, 8);
    chk("R8 small cur_ptr", cur_ptr, 32'h0007_0060);
    chk("R8 small xcnt zero", cur_xcnt, 16'hFFFF);
  endtask

  task automatic t_large_chain();
    mem[8'h40] = 16'h00A0; mem[8'h41] = 0; mem[8'h42] = 16'h0200; mem[8'h43] = 0;
    mem[8'h44] = mk(4, 9, 0); mem[8'h45] = 4; mem[8'h46] = 1; mem[8'h47] = 0; mem[8'h48] = 0;
    mem[8'h50] = 16'h00C0; mem[8'h51] = 0; mem[8'h52] = 16'h0301; mem[8'h53] = 0;
    mem[8'h54] = mk(0, 0, 0); mem[8'h55] = 7; mem[8'h56] = 1; mem[8'h57] = 1; mem[8'h58] = 0;
    cfg_in = mk(4, 9, 0); next_ptr_in = 32'h1234_0080;
    pulse_start(); wait_end();
    chk("R5 large done", got_d, 1);
    chk("R5 large full pointer", next_ptr, 32'h0000_00A0);
    chk("R5 large beats", nbeats - b0, 9);
    chk("R8 large cur_ycnt", cur_ycnt, 16'hFFFF);
    pulse_unit(); wait_end();
    chk("R10 chain done", got_d, 1);
    chk("R10 chain first addr", baddr[b0[5:0]], 32'hA0);
    chk("R10 chain next", next_ptr, 32'hC0);
    chk("R10 chain cfg", cfg, mk(0, 0, 0));
    chk("R10 chain cur_addr", cur_addr, 32'h301);
    chk("R10 chain xcnt", cur_xcnt, 7);
  endtask

  task automatic t_partial();
    mem[8'h70] = 16'h0100; mem[8'h71] = 16'h0001; mem[8'h72] = 16'h0040;
    cfg_in = mk(4, 3, 0); next_ptr_in = 32'hE0; saddr_in = 32'hDEAD_0000; xcnt_in = 16'h0022;
    pulse_start(); wait_end();
    chk("R6 short desc done", got_d, 1);
    chk("R6 short next", next_ptr, 32'h0001_0100);
    chk("R6 short saddr keeps high", saddr, 32'hDEAD_0040);
    chk("R6 short xcnt kept", xcnt, 16'h0022);
  endtask

  task automatic t_align();
    cfg_in = mk(0, 0, 2); saddr_in = 32'h1002;
    pulse_start(); wait_end();
    chk("R9 word misalign", {got_a, got_d, active}, 3'b100);
    cfg_in = mk(1, 0, 1); saddr_in = 32'h1001;
    pulse_start(); wait_end();
    chk("R9 half misalign", {got_a, got_d, active}, 3'b100);
    cfg_in = mk(0, 0, 0); saddr_in = 32'h1003;
    pulse_start(); wait_end();
    chk("R9 byte any addr", {got_a, got_d}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stop();
    t_auto();
    t_bad();
    t_array(1'b0);
    t_array(1'b1);
    t_small();
    t_large_chain();
    t_partial();
    t_align();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule